// File: doc/BRIEF.md
# Memory Window Router with Indirect Access Port

This block sits in front of an internal RAM. It decides which requests from processing channels and instruction dispatchers the RAM claims. Software programs a 64 KB window base and sets an enable bit. A request whose upper address half matches that base is then served by the RAM. A second 64 KB window, the discard bucket, can be placed anywhere. Any request that lands in it is swallowed: reads return zero and writes are dropped. When both windows sit on the same base, the bucket takes precedence. The bucket window always decodes, so after reset it covers the range starting at address zero.

Every request gets exactly one response, one cycle later. The response carries a target code that says who claimed it, along with the read data.

A register bus reaches the same RAM without going through the window. It uses a pointer register and a data register. Each data access moves the pointer forward by one 32-bit word, and the pointer wraps inside 64 KB. Two control bits freeze the pointer, one for read accesses and one for write accesses.

Top module: `mem_window_router`

## Requirements
- R1: After reset, the base, control, bucket-base and pointer registers all read as zero, memory claiming is off, and no response is pending.
- R2: Register map on `cfg_sel`: 0 is the window base, 1 is control, 2 is the bucket base, 3 is the pointer and 4 is data. The two base registers keep only write bits 31..16 and read bits 15..0 as zero. Control keeps only bits 2..0 (bit 0 enable, bit 1 hold-on-read, bit 2 hold-on-write) and reads all other bits as zero.
- R3: While control bit 0 is set, a request whose address bits 31..16 equal the window base gets target code 1 (memory). A read returns the addressed RAM word and a write updates it. Any other address, outside both windows, gets target code 0 (none).
- R4: While control bit 0 is clear, a request in the window gets target code 0, reads return zero and writes leave the RAM unchanged.
- R5: A request whose address bits 31..16 equal the bucket base gets target code 2, even when the window base is equal and enabled. Its read data is zero and a write to it changes no RAM word.
- R6: Every request cycle produces exactly one `rsp_valid` pulse in the next cycle. For writes and unclaimed requests, `rsp_rdata` is zero.
- R7: The pointer register reads as a byte address with bits 1..0 zero and bits 31..16 zero. A write loads it from `cfg_wdata` bits 15..2. A data-register access reads or writes the RAM word the pointer selects.
- R8: Each data-register access advances the pointer by 4 bytes, and 0xFFFC wraps to 0x0000.
- R9: Control bit 1 keeps the pointer still after data reads and control bit 2 keeps it still after data writes. Each bit acts only on its own direction.
- R10: The RAM word is chosen by address bits MEM_AW+1..2. The request path and the indirect path share one RAM, so a word written through one is read back through the other.
- R11: Every register read produces one `cfg_rvalid` pulse in the next cycle, with the read value on `cfg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Register bus access strobe |
| cfg_write | input | 1 | 1 = register write, 0 = register read |
| cfg_sel | input | 3 | Register select (see R2) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rvalid | output | 1 | Register read data valid |
| cfg_rdata | output | 32 | Register read data |
| req_valid | input | 1 | Request strobe from a channel or dispatcher |
| req_write | input | 1 | 1 = write request |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 32 | Request write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_target | output | 2 | 0 none, 1 memory, 2 bucket |
| rsp_rdata | output | 32 | Response read data |

## Verification
The assertions on the pointer assume at most one register-bus access per cycle. A pointer write and a data access never arrive together, so each pointer step is judged on its own. The response assertions assume that window bases and the enable bit are not changed while a request to that window is in flight. The stimulus respects both rules. It issues one operation per cycle, either a register access or a request and never both. It reprograms the base, bucket and control registers only between requests.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int WIN_W  = 16;
  localparam int BASE_W = ADDR_W - WIN_W;
  localparam int PTR_W  = WIN_W - 2;
  localparam int SEL_W  = 3;
  localparam int CTL_W  = 3;

  localparam logic [SEL_W-1:0] SEL_BASE = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd1;
  localparam logic [SEL_W-1:0] SEL_BKT  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_PTR  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_DATA = 3'd4;

  localparam int CTL_EN      = 0;
  localparam int CTL_HOLD_RD = 1;
  localparam int CTL_HOLD_WR = 2;

  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_MEM    = 2'd1,
    TGT_BUCKET = 2'd2
  } tgt_e;

  function automatic logic page_match(input logic [BASE_W-1:0] page,
                                      input logic [BASE_W-1:0] base);
    return page == base;
  endfunction

  function automatic tgt_e pick_target(input logic in_mem, input logic in_bkt,
                                       input logic enabled);
    if (in_bkt)                return TGT_BUCKET;
    else if (in_mem && enabled) return TGT_MEM;
    else                        return TGT_NONE;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_advance(input logic [PTR_W-1:0] p,
                                                   input logic hold);
    return hold ? p : p + PTR_W'(1);
  endfunction

  function automatic logic [DATA_W-1:0] ptr_to_bytes(input logic [PTR_W-1:0] p);
    return {{(DATA_W-WIN_W){1'b0}}, p, 2'b00};
  endfunction

  function automatic logic [PTR_W-1:0] bytes_to_ptr(input logic [DATA_W-1:0] d);
    return d[WIN_W-1:2];
  endfunction
endpackage

// File: rtl/mwr_regfile.sv
module mwr_regfile
  import mwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic              cfg_write,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [BASE_W-1:0] mem_base,
  output logic [BASE_W-1:0] bkt_base,
  output logic              map_en,
  output logic              hold_rd,
  output logic              hold_wr,
  output logic [PTR_W-1:0]  ptr,
  output logic              data_rd,
  output logic              data_wr,
  output logic [DATA_W-1:0] cfg_rdata
);
  logic [CTL_W-1:0]  ctrl;
  logic              reg_wr, reg_rd;
  logic [DATA_W-1:0] readback;

  assign reg_wr  = cfg_valid &&  cfg_write;
  assign reg_rd  = cfg_valid && !cfg_write;
  assign data_rd = reg_rd && (cfg_sel == SEL_DATA);
  assign data_wr = reg_wr && (cfg_sel == SEL_DATA);

  assign map_en  = ctrl[CTL_EN];
  assign hold_rd = ctrl[CTL_HOLD_RD];
  assign hold_wr = ctrl[CTL_HOLD_WR];

  always_comb begin
    case (cfg_sel)
      SEL_BASE: readback = {mem_base, {WIN_W{1'b0}}};
      SEL_CTRL: readback = {{(DATA_W-CTL_W){1'b0}}, ctrl};
      SEL_BKT:  readback = {bkt_base, {WIN_W{1'b0}}};
      SEL_PTR:  readback = ptr_to_bytes(ptr);
      default:  readback = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_base  <= '0;
      bkt_base  <= '0;
      ctrl      <= '0;
      ptr       <= '0;
      cfg_rdata <= '0;
    end else begin
      if (reg_wr) begin
        case (cfg_sel)
          SEL_BASE: mem_base <= cfg_wdata[DATA_W-1:WIN_W];
          SEL_CTRL: ctrl     <= cfg_wdata[CTL_W-1:0];
          SEL_BKT:  bkt_base <= cfg_wdata[DATA_W-1:WIN_W];
          SEL_PTR:  ptr      <= bytes_to_ptr(cfg_wdata);
          default:  ;
        endcase
      end
      if (data_rd) ptr <= ptr_advance(ptr, hold_rd);
      if (data_wr) ptr <= ptr_advance(ptr, hold_wr);
      if (reg_rd)  cfg_rdata <= readback;
    end
  end

  // R8: an unheld data read moves the pointer one word on
  p_step_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !hold_rd |=> ptr == PTR_W'($past(ptr) + 1'b1));
  // R8: an unheld data write moves the pointer one word on
  p_step_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && !hold_wr |=> ptr == PTR_W'($past(ptr) + 1'b1));
  // R9: held directions leave the pointer where it was
  p_hold_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && hold_rd |=> $stable(ptr));
  p_hold_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && hold_wr |=> $stable(ptr));
  // R2: base readback never shows low bits
  p_base_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && (cfg_sel == SEL_BASE || cfg_sel == SEL_BKT)
      |=> cfg_rdata[WIN_W-1:0] == '0);
endmodule

// File: rtl/mwr_decoder.sv
module mwr_decoder
  import mwr_pkg::*;
(
  input  logic [BASE_W-1:0] req_page,
  input  logic [BASE_W-1:0] mem_base,
  input  logic [BASE_W-1:0] bkt_base,
  input  logic              map_en,
  output logic              hit_mem,
  output logic              hit_bkt,
  output tgt_e              target
);
  assign hit_mem = page_match(req_page, mem_base);
  assign hit_bkt = page_match(req_page, bkt_base);
  assign target  = pick_target(hit_mem, hit_bkt, map_en);
endmodule

// File: rtl/mwr_ram.sv
module mwr_ram
  import mwr_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [AW-1:0]     a_idx,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_we,
  input  logic [AW-1:0]     b_idx,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] store [DEPTH];

  // port A (request path) is written last, so it wins a same-word collision
  always_ff @(posedge clk) begin
    if (b_we) store[b_idx] <= b_wdata;
    if (a_we) store[a_idx] <= a_wdata;
    a_rdata <= store[a_idx];
    b_rdata <= store[b_idx];
  end
endmodule

// File: rtl/mem_window_router.sv
module mem_window_router
  import mwr_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_valid,
  input  logic        cfg_write,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic        cfg_rvalid,
  output logic [31:0] cfg_rdata,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [1:0]  rsp_target,
  output logic [31:0] rsp_rdata
);
  logic [BASE_W-1:0] mem_base, bkt_base;
  logic              map_en, hold_rd, hold_wr;
  logic [PTR_W-1:0]  ptr;
  logic              data_rd, data_wr;
  logic [DATA_W-1:0] cfg_rdata_regs;
  logic              hit_mem, hit_bkt;
  tgt_e              target;
  logic              mem_wr_claim, mem_rd_claim;
  logic              mem_rd_q, data_rd_q;
  logic [DATA_W-1:0] ram_a_q, ram_b_q;
  logic              unused_bits;

  assign unused_bits = ^{req_addr[1:0], req_addr[WIN_W-1:MEM_AW+2], ptr[PTR_W-1:MEM_AW]};

  mwr_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_write (cfg_write),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .mem_base  (mem_base),
    .bkt_base  (bkt_base),
    .map_en    (map_en),
    .hold_rd   (hold_rd),
    .hold_wr   (hold_wr),
    .ptr       (ptr),
    .data_rd   (data_rd),
    .data_wr   (data_wr),
    .cfg_rdata (cfg_rdata_regs)
  );

  mwr_decoder u_dec (
    .req_page (req_addr[ADDR_W-1:WIN_W]),
    .mem_base (mem_base),
    .bkt_base (bkt_base),
    .map_en   (map_en),
    .hit_mem  (hit_mem),
    .hit_bkt  (hit_bkt),
    .target   (target)
  );

  assign mem_wr_claim = req_valid &&  req_write && (target == TGT_MEM);
  assign mem_rd_claim = req_valid && !req_write && (target == TGT_MEM);

  mwr_ram #(.AW(MEM_AW)) u_ram (
    .clk     (clk),
    .a_we    (mem_wr_claim),
    .a_idx   (req_addr[MEM_AW+1:2]),
    .a_wdata (req_wdata),
    .a_rdata (ram_a_q),
    .b_we    (data_wr),
    .b_idx   (ptr[MEM_AW-1:0]),
    .b_wdata (cfg_wdata),
    .b_rdata (ram_b_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_target <= TGT_NONE;
      mem_rd_q   <= 1'b0;
      cfg_rvalid <= 1'b0;
      data_rd_q  <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_target <= req_valid ? target : TGT_NONE;
      mem_rd_q   <= mem_rd_claim;
      cfg_rvalid <= cfg_valid && !cfg_write;
      data_rd_q  <= data_rd;
    end
  end

  assign rsp_rdata = mem_rd_q  ? ram_a_q : '0;
  assign cfg_rdata = data_rd_q ? ram_b_q : cfg_rdata_regs;

  // R6: one response per request, one cycle later
  p_rsp_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R4: memory claims only while mapping was enabled
  p_mem_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_target == TGT_MEM |-> $past(map_en));
  // R5: bucket wins and returns zero
  p_bkt_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && hit_bkt |=> rsp_target == TGT_BUCKET);
  p_bkt_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_target == TGT_BUCKET |-> rsp_rdata == '0);
  // R11: register reads answer the next cycle
  p_cfg_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_write |=> cfg_rvalid);
endmodule

// File: tb/mem_window_router_test.sv
module mem_window_router_test;
  localparam int MEM_AW = 8;
  localparam int DEPTH  = 1 << MEM_AW;

  logic        clk, rst_n;
  logic        cfg_valid, cfg_write;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        cfg_rvalid;
  logic        req_valid, req_write;
  logic [31:0] req_addr, req_wdata, rsp_rdata;
  logic        rsp_valid;
  logic [1:0]  rsp_target;

  mem_window_router #(.MEM_AW(MEM_AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_target(rsp_target),
    .rsp_rdata(rsp_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    bit          is_rsp;
    logic [1:0]  tgt;
    logic [31:0] data;
    int          due;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  exp_t        cur;
  int          checks, fails, cyc;
  bit          done;
  logic [31:0] m_mem [DEPTH];
  logic [15:0] m_base, m_bkt, m_ptr;
  logic [2:0]  m_ctl;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [31:0] pat(int i);
    return 32'hA500_0000 ^ (i * 32'h0001_0203);
  endfunction

  task automatic cfg_wr(logic [2:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_valid = 1; cfg_write = 1; cfg_sel = sel; cfg_wdata = d;
    case (sel)
      3'd0: m_base = d[31:16];
      3'd1: m_ctl  = d[2:0];
      3'd2: m_bkt  = d[31:16];
      3'd3: m_ptr  = d[15:0] & 16'hFFFC;
      3'd4: begin
        m_mem[m_ptr[MEM_AW+1:2]] = d;
        if (!m_ctl[2]) m_ptr = m_ptr + 16'd4;
      end
      default: ;
    endcase
    @(posedge clk); #1;
    cfg_valid = 0; cfg_write = 0;
  endtask

  task automatic cfg_rd(logic [2:0] sel, string tag);
    exp_t e;
    @(negedge clk);
    cfg_valid = 1; cfg_write = 0; cfg_sel = sel;
    case (sel)
      3'd0: e.data = {m_base, 16'h0};
      3'd1: e.data = {29'h0, m_ctl};
      3'd2: e.data = {m_bkt, 16'h0};
      3'd3: e.data = {16'h0, m_ptr};
      3'd4: begin
        e.data = m_mem[m_ptr[MEM_AW+1:2]];
        if (!m_ctl[1]) m_ptr = m_ptr + 16'd4;
      end
      default: e.data = 32'h0;
    endcase
    e.is_rsp = 0; e.tgt = 2'd0; e.due = cyc + 1; e.tag = tag;
    sbq.push_back(e);
    @(posedge clk); #1;
    cfg_valid = 0;
  endtask

  task automatic bus(bit w, logic [31:0] a, logic [31:0] d, string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    if (a[31:16] == m_bkt)                     e.tgt = 2'd2;
    else if (a[31:16] == m_base && m_ctl[0])   e.tgt = 2'd1;
    else                                       e.tgt = 2'd0;
    e.data = (e.tgt == 2'd1 && !w) ? m_mem[a[MEM_AW+1:2]] : 32'h0;
    if (e.tgt == 2'd1 && w) m_mem[a[MEM_AW+1:2]] = d;
    e.is_rsp = 1; e.due = cyc + 1; e.tag = tag;
    sbq.push_back(e);
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
  endtask

  // monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid || cfg_rvalid) begin
        if (sbq.size() == 0) begin
          check(0, "R6", "unexpected response", {31'h0, rsp_valid}, 32'h0);
        end else begin
          cur = sbq.pop_front();
          check(cur.is_rsp == rsp_valid, cur.tag, "response kind",
                {31'h0, rsp_valid}, {31'h0, cur.is_rsp});
          check(cur.due == cyc, cur.tag, "response cycle", cyc, cur.due);
          if (cur.is_rsp) begin
            check(rsp_target == cur.tgt, cur.tag, "target",
                  {30'h0, rsp_target}, {30'h0, cur.tgt});
            check(rsp_rdata == cur.data, cur.tag, "rsp data", rsp_rdata, cur.data);
          end else begin
            check(cfg_rdata == cur.data, cur.tag, "cfg data", cfg_rdata, cur.data);
          end
        end
      end else if (sbq.size() > 0 && sbq[0].due <= cyc) begin
        cur = sbq.pop_front();
        check(0, cur.tag, "missing response", 32'h0, 32'h1);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, got %0d expected 0 pending", sbq.size());
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; cyc = 0; done = 0;
    m_base = 0; m_bkt = 0; m_ptr = 0; m_ctl = 0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 32'h0;
    rst_n = 0; cfg_valid = 0; cfg_write = 0; cfg_sel = 0; cfg_wdata = 0;
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check(!rsp_valid && !cfg_rvalid, "R1", "idle after reset",
          {30'h0, rsp_valid, cfg_rvalid}, 32'h0);

    cfg_rd(3'd0, "R1 base reset");
    cfg_rd(3'd1, "R1 ctrl reset");
    cfg_rd(3'd2, "R1 bucket reset");
    cfg_rd(3'd3, "R1 pointer reset");
    bus(0, 32'h0000_0010, 0, "R5 bucket at reset base");

    cfg_wr(3'd0, 32'h1234_ABCD);
    cfg_rd(3'd0, "R2 base low bits dropped");
    cfg_wr(3'd2, 32'hFFFF_FFFF);
    cfg_rd(3'd2, "R2 bucket low bits dropped");
    cfg_wr(3'd1, 32'hFFFF_FFF8);
    cfg_rd(3'd1, "R2 ctrl spare bits");
    cfg_wr(3'd2, 32'h7777_0000);
    bus(1, 32'h1234_0010, 32'hDEAD_BEEF, "R4 write while disabled");

    cfg_wr(3'd3, 32'h0);
    for (int i = 0; i < DEPTH; i++) cfg_wr(3'd4, pat(i));
    cfg_rd(3'd3, "R8 pointer after fill");

    cfg_wr(3'd1, 32'h1);
    bus(0, 32'h1234_0000, 0, "R3 read word 0");
    bus(0, 32'h1234_0010, 0, "R3 read word 4");
    bus(0, 32'h1234_03FC, 0, "R3 read last word");
    bus(0, 32'h1235_0000, 0, "R3 outside window");
    bus(0, 32'h1234_0404, 0, "R10 alias of word 1");
    bus(1, 32'h1234_0020, 32'hCAFE_F00D, "R3 write");
    cfg_wr(3'd3, 32'h20);
    cfg_rd(3'd4, "R10 request write seen indirectly");

    cfg_wr(3'd1, 32'h0);
    bus(1, 32'h1234_0030, 32'h1111_1111, "R4 write disabled");
    bus(0, 32'h1234_0030, 0, "R4 read disabled");
    cfg_wr(3'd1, 32'h1);
    bus(0, 32'h1234_0030, 0, "R4 write had no effect");

    cfg_wr(3'd2, 32'h1234_0000);
    bus(0, 32'h1234_0030, 0, "R5 bucket priority read");
    bus(1, 32'h1234_0030, 32'h2222_2222, "R5 bucket write");
    cfg_wr(3'd2, 32'h7777_0000);
    bus(0, 32'h1234_0030, 0, "R5 bucket write discarded");
    bus(1, 32'h1234_0008, 32'h0000_0042, "R6 write response data");

    cfg_wr(3'd3, 32'h0000_FFFC);
    cfg_wr(3'd4, 32'h5A5A_0001);
    cfg_rd(3'd3, "R8 pointer wrap");
    bus(0, 32'h1234_03FC, 0, "R7 indirect write at top word");

    cfg_wr(3'd3, 32'h8);
    cfg_wr(3'd1, 32'h3);
    cfg_rd(3'd4, "R9 hold on read first");
    cfg_rd(3'd4, "R9 hold on read again");
    cfg_rd(3'd3, "R9 pointer held after reads");
    cfg_wr(3'd4, 32'h0BAD_0001);
    cfg_rd(3'd3, "R9 write still steps");

    cfg_wr(3'd1, 32'h5);
    cfg_wr(3'd4, 32'h0000_00AA);
    cfg_wr(3'd4, 32'h0000_00BB);
    cfg_rd(3'd3, "R9 pointer held after writes");
    cfg_rd(3'd4, "R9 last held write wins");
    cfg_rd(3'd3, "R9 read still steps");
    cfg_rd(3'd7, "R11 unused select reads zero");

    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "R6", "pending responses", sbq.size(), 32'h0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule